// File: doc/BRIEF.md
# Time-Triggered Pulse Generator

This block holds a free-running time base, kept both as seconds plus nanoseconds for software reads and as one flat nanosecond count for comparison. Software programs a target time, an output pattern, a pulse width, a cycle width and a cycle count, then arms the unit. When the running time reaches the target, the unit drives one of sixteen general-purpose outputs. The waveform can be a single edge, a single pulse, a periodic pulse train of finite or unbounded length, or a level taken from a register. Sticky done, error and interrupt flags report the outcome and are cleared by writing ones.

The sequencer has three states. `ST_IDLE` waits for an arm command. Arming with a target in the future takes the transition *arm-ok* to `ST_WAIT`. Arming with a target in the past takes *arm-late*, which stays in `ST_IDLE` and raises the error flag. In `ST_WAIT` the transition *fire* happens when the time reaches the event time. For edge and level patterns it returns to `ST_IDLE` with done set. For pulse and train patterns it goes to `ST_ON`. In `ST_ON` the transition *pulse-end* happens when the pulse width has elapsed. For a train with cycles left it goes back to `ST_WAIT`, with the event time advanced by one cycle width. Otherwise it goes to `ST_IDLE` with done set. From any state, the transition *stop* goes to `ST_IDLE`.

The time base advances by 40 ns per clock. The nanosecond field wraps at one second into the seconds field.

Top module: `trig_pulse_gen`

## Requirements
- R1: The time value read at address 8 advances by exactly 40 ns per clock cycle.
- R2: Pattern code 1 (rising edge) drives the output to 0 at arming and to 1 once the target is reached. Pattern code 0 (falling edge) drives it to 1 at arming and to 0 at the target. Done is set in both cases.
- R3: Pattern code 3 (high pulse) holds the output high for exactly pulse_width×8 ns from the target. Pattern code 2 (low pulse) holds it low for the same time, with the output idle high outside the pulse. Done is set afterwards.
- R4: Pattern codes 5 (high train) and 4 (low train) with cycle count N>0 produce N pulses starting at target + n·cycle_width. The output then returns to its idle level and done is set.
- R5: A cycle count of 0 makes the train run with no end: active stays 1 and done stays 0.
- R6: In train modes, a pulse width of at least the cycle width is cut to cycle_width − 40 ns. The output is then at idle for one clock in every cycle.
- R7: Pattern code 6 sets the output, at the target, to bit 0 of the level register (address 10).
- R8: Arming with a target earlier than the current time sets the error flag (status bit 1), leaves active at 0 and does not change the output.
- R9: Writing 1 to control bit 1 (stop) clears active and keeps the output at its present level.
- R10: Status bits (done bit 0, error bit 1, interrupt bit 2) are 0 after reset, stay set until written with a 1 at their position, and clear only the bits written.
- R11: The interrupt flag and the `irq` output are set at completion only when the notify bit (mode bit 3) is 1.
- R12: Mode bits 7:4 select which `gpo` bit carries the waveform. All other `gpo` bits stay 0, and all of `gpo` is 0 after reset.

Register map: 0 control (write bit0 arm, bit1 stop; read bit0 active), 1 status, 2 mode (bits 2:0 pattern), 3 target ns, 4 target s, 5 cycle width ns, 6 cycle count (16 bits), 7 pulse width (24 bits, 8 ns units), 8 time ns, 9 time s, 10 level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data, combinational |
| gpo | output | 16 | General-purpose outputs |
| irq | output | 1 | Interrupt flag |

## Verification
Each pattern code is armed against a target about 4 µs ahead, and the bench counts high cycles and rising edges on the selected output. This separates edge from pulse behaviour, high from low polarity, exact pulse width from off-by-one widths, and finite from unbounded trains. A train whose pulse width exceeds its cycle width tells the clamped case from a merged, never-idle output. A target in the past, a stop issued while the output is high, and notify on versus off separate the error, hold and interrupt paths. Choosing bit 5 as the output shows whether other outputs stay quiet.

// File: rtl/trig_pkg.sv
package trig_pkg;
    typedef enum logic [2:0] {
        PAT_FALL    = 3'd0,
        PAT_RISE    = 3'd1,
        PAT_LOPULSE = 3'd2,
        PAT_HIPULSE = 3'd3,
        PAT_LOTRAIN = 3'd4,
        PAT_HITRAIN = 3'd5,
        PAT_LEVEL   = 3'd6,
        PAT_RSVD    = 3'd7
    } pattern_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_ON   = 2'd2
    } state_t;

    localparam int unsigned ADDR_CTRL  = 0;
    localparam int unsigned ADDR_STAT  = 1;
    localparam int unsigned ADDR_MODE  = 2;
    localparam int unsigned ADDR_TNS   = 3;
    localparam int unsigned ADDR_TSEC  = 4;
    localparam int unsigned ADDR_CYCW  = 5;
    localparam int unsigned ADDR_CCNT  = 6;
    localparam int unsigned ADDR_PW    = 7;
    localparam int unsigned ADDR_NOWNS = 8;
    localparam int unsigned ADDR_NOWS  = 9;
    localparam int unsigned ADDR_LVL   = 10;

    function automatic logic pat_is_pulse(pattern_t p);
        return (p == PAT_LOPULSE) || (p == PAT_HIPULSE) ||
               (p == PAT_LOTRAIN) || (p == PAT_HITRAIN);
    endfunction

    function automatic logic pat_is_train(pattern_t p);
        return (p == PAT_LOTRAIN) || (p == PAT_HITRAIN);
    endfunction

    function automatic logic pat_keeps_level(pattern_t p);
        return (p == PAT_LEVEL) || (p == PAT_RSVD);
    endfunction
endpackage

// File: rtl/trig_timebase.sv
module trig_timebase #(
    parameter int unsigned TW         = 32,
    parameter int unsigned FW         = 64,
    parameter int unsigned STEP_NS    = 40,
    parameter int unsigned NS_PER_SEC = 1000000000
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [TW-1:0] now_sec,
    output logic [TW-1:0] now_ns,
    output logic [FW-1:0] now_flat
);
    logic [TW:0] ns_sum;

    assign ns_sum = {1'b0, now_ns} + (TW+1)'(STEP_NS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            now_sec  <= '0;
            now_ns   <= '0;
            now_flat <= '0;
        end else begin
            now_flat <= now_flat + FW'(STEP_NS);
            if (ns_sum >= (TW+1)'(NS_PER_SEC)) begin
                now_ns  <= TW'(ns_sum - (TW+1)'(NS_PER_SEC));
                now_sec <= now_sec + 1'b1;
            end else begin
                now_ns  <= ns_sum[TW-1:0];
            end
        end
    end
endmodule

// File: rtl/trig_regs.sv
module trig_regs
    import trig_pkg::*;
#(
    parameter int unsigned AW   = 4,
    parameter int unsigned TW   = 32,
    parameter int unsigned SELW = 4,
    parameter int unsigned CNTW = 16,
    parameter int unsigned PWW  = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [TW-1:0]   wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [TW-1:0]   rd_data,
    input  logic [TW-1:0]   now_sec,
    input  logic [TW-1:0]   now_ns,
    input  logic            active,
    input  logic            set_done,
    input  logic            set_err,
    output logic            arm_cmd,
    output logic            stop_cmd,
    output pattern_t        pattern,
    output logic            notify,
    output logic [SELW-1:0] sel,
    output logic [TW-1:0]   tgt_ns,
    output logic [TW-1:0]   tgt_sec,
    output logic [TW-1:0]   cyc_w,
    output logic [CNTW-1:0] cyc_cnt,
    output logic [PWW-1:0]  pw,
    output logic            lvl,
    output logic            done_f,
    output logic            err_f,
    output logic            irq_f
);
    logic wr_ctrl, wr_stat;

    assign wr_ctrl  = wr_en && (wr_addr == AW'(ADDR_CTRL));
    assign wr_stat  = wr_en && (wr_addr == AW'(ADDR_STAT));
    assign stop_cmd = wr_ctrl && wr_data[1];
    assign arm_cmd  = wr_ctrl && wr_data[0] && !wr_data[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pattern <= PAT_FALL;
            notify  <= 1'b0;
            sel     <= '0;
            tgt_ns  <= '0;
            tgt_sec <= '0;
            cyc_w   <= '0;
            cyc_cnt <= '0;
            pw      <= '0;
            lvl     <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_addr)
                AW'(ADDR_MODE): begin
                    pattern <= pattern_t'(wr_data[2:0]);
                    notify  <= wr_data[3];
                    sel     <= wr_data[4 +: SELW];
                end
                AW'(ADDR_TNS):  tgt_ns  <= wr_data;
                AW'(ADDR_TSEC): tgt_sec <= wr_data;
                AW'(ADDR_CYCW): cyc_w   <= wr_data;
                AW'(ADDR_CCNT): cyc_cnt <= wr_data[CNTW-1:0];
                AW'(ADDR_PW):   pw      <= wr_data[PWW-1:0];
                AW'(ADDR_LVL):  lvl     <= wr_data[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_f <= 1'b0;
            err_f  <= 1'b0;
            irq_f  <= 1'b0;
        end else begin
            if (set_done)                    done_f <= 1'b1;
            else if (wr_stat && wr_data[0])  done_f <= 1'b0;
            if (set_err)                     err_f  <= 1'b1;
            else if (wr_stat && wr_data[1])  err_f  <= 1'b0;
            if (set_done && notify)          irq_f  <= 1'b1;
            else if (wr_stat && wr_data[2])  irq_f  <= 1'b0;
        end
    end

    always_comb begin
        unique case (rd_addr)
            AW'(ADDR_CTRL):  rd_data = TW'(active);
            AW'(ADDR_STAT):  rd_data = TW'({irq_f, err_f, done_f});
            AW'(ADDR_MODE):  rd_data = TW'({sel, notify, pattern});
            AW'(ADDR_TNS):   rd_data = tgt_ns;
            AW'(ADDR_TSEC):  rd_data = tgt_sec;
            AW'(ADDR_CYCW):  rd_data = cyc_w;
            AW'(ADDR_CCNT):  rd_data = TW'(cyc_cnt);
            AW'(ADDR_PW):    rd_data = TW'(pw);
            AW'(ADDR_NOWNS): rd_data = now_ns;
            AW'(ADDR_NOWS):  rd_data = now_sec;
            AW'(ADDR_LVL):   rd_data = TW'(lvl);
            default:         rd_data = '0;
        endcase
    end
endmodule

// File: rtl/trig_fsm.sv
module trig_fsm
    import trig_pkg::*;
#(
    parameter int unsigned TW         = 32,
    parameter int unsigned FW         = 64,
    parameter int unsigned CNTW       = 16,
    parameter int unsigned PWW        = 24,
    parameter int unsigned STEP_NS    = 40,
    parameter int unsigned NS_PER_SEC = 1000000000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm_cmd,
    input  logic            stop_cmd,
    input  pattern_t        pattern,
    input  logic [TW-1:0]   tgt_sec,
    input  logic [TW-1:0]   tgt_ns,
    input  logic [TW-1:0]   cyc_w,
    input  logic [CNTW-1:0] cyc_cnt,
    input  logic [PWW-1:0]  pw,
    input  logic            lvl,
    input  logic [FW-1:0]   now_flat,
    output logic            level,
    output logic            active,
    output logic            set_done,
    output logic            set_err
);
    state_t state_q, state_d;

    logic [FW-1:0]   evt_q, end_q, tgt_flat, pw_ns, eff_ns, cyc_flat;
    logic [CNTW:0]   fired_q;
    logic            late, hit, end_hit, last_cycle, pulse_lvl, edge_lvl;

    assign tgt_flat   = FW'(tgt_sec) * FW'(NS_PER_SEC) + FW'(tgt_ns);
    assign late       = tgt_flat < now_flat;
    assign hit        = now_flat >= evt_q;
    assign end_hit    = now_flat >= end_q;
    assign pw_ns      = FW'({pw, 3'b000});
    assign cyc_flat   = FW'(cyc_w);
    assign pulse_lvl  = pattern[0];
    assign edge_lvl   = pat_keeps_level(pattern) ? lvl : pattern[0];
    assign last_cycle = (cyc_cnt != '0) && ((fired_q + 1'b1) == {1'b0, cyc_cnt});

    always_comb begin
        if (pat_is_train(pattern) && (pw_ns >= cyc_flat))
            eff_ns = (cyc_flat > FW'(STEP_NS)) ? cyc_flat - FW'(STEP_NS) : '0;
        else
            eff_ns = pw_ns;
    end

    always_comb begin
        state_d = state_q;
        if (stop_cmd) begin
            state_d = ST_IDLE;
        end else if (arm_cmd) begin
            state_d = late ? ST_IDLE : ST_WAIT;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_WAIT: if (hit) state_d = pat_is_pulse(pattern) ? ST_ON : ST_IDLE;
                ST_ON:   if (end_hit)
                             state_d = (pat_is_train(pattern) && !last_cycle) ? ST_WAIT : ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level    <= 1'b0;
            active   <= 1'b0;
            set_done <= 1'b0;
            set_err  <= 1'b0;
            evt_q    <= '0;
            end_q    <= '0;
            fired_q  <= '0;
        end else begin
            set_done <= 1'b0;
            set_err  <= 1'b0;
            if (stop_cmd) begin
                active <= 1'b0;
            end else if (arm_cmd) begin
                fired_q <= '0;
                if (late) begin
                    set_err <= 1'b1;
                    active  <= 1'b0;
                end else begin
                    active <= 1'b1;
                    evt_q  <= tgt_flat;
                    if (!pat_keeps_level(pattern)) level <= ~pattern[0];
                end
            end else begin
                unique case (state_q)
                    ST_IDLE: ;
                    ST_WAIT: if (hit) begin
                        if (pat_is_pulse(pattern)) begin
                            level <= pulse_lvl;
                            end_q <= evt_q + eff_ns;
                        end else begin
                            level    <= edge_lvl;
                            active   <= 1'b0;
                            set_done <= 1'b1;
                        end
                    end
                    ST_ON: if (end_hit) begin
                        level <= ~pulse_lvl;
                        if (pat_is_train(pattern) && !last_cycle) begin
                            fired_q <= fired_q + 1'b1;
                            evt_q   <= evt_q + cyc_flat;
                        end else begin
                            active   <= 1'b0;
                            set_done <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/trig_pulse_gen.sv
module trig_pulse_gen
    import trig_pkg::*;
#(
    parameter int unsigned AW         = 4,
    parameter int unsigned TW         = 32,
    parameter int unsigned SELW       = 4,
    parameter int unsigned CNTW       = 16,
    parameter int unsigned PWW        = 24,
    parameter int unsigned STEP_NS    = 40,
    parameter int unsigned NS_PER_SEC = 1000000000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [TW-1:0]        wr_data,
    input  logic [AW-1:0]        rd_addr,
    output logic [TW-1:0]        rd_data,
    output logic [(1<<SELW)-1:0] gpo,
    output logic                 irq
);
    localparam int unsigned NOUT = 1 << SELW;
    localparam int unsigned FW   = 2 * TW;

    logic [TW-1:0]   now_sec, now_ns, tgt_ns, tgt_sec, cyc_w;
    logic [FW-1:0]   now_flat;
    logic [CNTW-1:0] cyc_cnt;
    logic [PWW-1:0]  pw;
    logic [SELW-1:0] sel;
    pattern_t        pattern;
    logic            notify, lvl, level, active, set_done, set_err;
    logic            arm_cmd, stop_cmd, done_f, err_f, irq_f;

    trig_timebase #(.TW(TW), .FW(FW), .STEP_NS(STEP_NS), .NS_PER_SEC(NS_PER_SEC)) u_tb (
        .clk(clk), .rst_n(rst_n), .now_sec(now_sec), .now_ns(now_ns), .now_flat(now_flat)
    );

    trig_regs #(.AW(AW), .TW(TW), .SELW(SELW), .CNTW(CNTW), .PWW(PWW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .now_sec(now_sec), .now_ns(now_ns),
        .active(active), .set_done(set_done), .set_err(set_err),
        .arm_cmd(arm_cmd), .stop_cmd(stop_cmd), .pattern(pattern), .notify(notify),
        .sel(sel), .tgt_ns(tgt_ns), .tgt_sec(tgt_sec), .cyc_w(cyc_w), .cyc_cnt(cyc_cnt),
        .pw(pw), .lvl(lvl), .done_f(done_f), .err_f(err_f), .irq_f(irq_f)
    );

    trig_fsm #(.TW(TW), .FW(FW), .CNTW(CNTW), .PWW(PWW), .STEP_NS(STEP_NS),
               .NS_PER_SEC(NS_PER_SEC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .arm_cmd(arm_cmd), .stop_cmd(stop_cmd),
        .pattern(pattern), .tgt_sec(tgt_sec), .tgt_ns(tgt_ns), .cyc_w(cyc_w),
        .cyc_cnt(cyc_cnt), .pw(pw), .lvl(lvl), .now_flat(now_flat),
        .level(level), .active(active), .set_done(set_done), .set_err(set_err)
    );

    for (genvar i = 0; i < NOUT; i++) begin : g_out
        assign gpo[i] = (sel == SELW'(i)) && level;
    end

    assign irq = irq_f;
endmodule

// File: rtl/trig_pulse_gen_chk.sv
module trig_pulse_gen_chk #(
    parameter int unsigned NOUT = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NOUT-1:0] gpo,
    input logic            irq,
    input logic            active,
    input logic            done_f,
    input logic            err_f,
    input logic            stop_cmd
);
    assert_single_output_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gpo));

    assert_irq_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> done_f);

    assert_error_not_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_f) |-> !active);

    assert_stop_holds_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_cmd |=> (!active && $stable(gpo)));

    assert_done_ends_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_f) |-> !active);
endmodule

bind trig_pulse_gen trig_pulse_gen_chk #(.NOUT(1 << SELW)) u_chk (
    .clk(clk), .rst_n(rst_n), .gpo(gpo), .irq(irq), .active(active),
    .done_f(done_f), .err_f(err_f), .stop_cmd(stop_cmd)
);

// File: tb/sim_trig_pulse_gen.sv
module sim_trig_pulse_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [15:0] gpo;
    logic        irq;

    int checks = 0;
    int failures = 0;

    trig_pulse_gen u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .gpo(gpo), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input int a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = 4'(a);
        #1 d = rd_data;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic arm_at(input int delta);
        logic [31:0] t;
        bus_rd(8, t);
        bus_wr(3, t + 32'(delta));
        bus_wr(4, 32'd0);
        bus_wr(0, 32'd1);
    endtask

    task automatic watch(input int n, input int b, output int highs, output int rises,
                         output int stray);
        logic prev, cur;
        highs = 0; rises = 0; stray = 0;
        #1 prev = gpo[b];
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            cur = gpo[b];
            if (cur) highs++;
            if (cur && !prev) rises++;
            if ((gpo & ~(16'h1 << b)) != 16'h0) stray++;
            prev = cur;
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check(gpo == 16'h0, "R12 gpo after reset", gpo, 0);
        check(irq == 1'b0, "R10 irq after reset", irq, 0);
        bus_rd(1, d);
        check(d == 32'd0, "R10 status after reset", d, 0);
    endtask

    task automatic t_timebase;
        logic [31:0] a, b;
        bus_rd(8, a);
        cycles(10);
        bus_rd(8, b);
        check(b - a == 32'd440, "R1 time step", b - a, 440);
    endtask

    task automatic t_edges;
        logic [31:0] d;
        bus_wr(2, 32'h0000_0009);            // rise, notify, sel 0
        arm_at(4000);
        cycles(40);
        check(gpo[0] == 1'b0, "R2 rise primed low", gpo[0], 0);
        cycles(110);
        check(gpo[0] == 1'b1, "R2 rise final high", gpo[0], 1);
        bus_rd(1, d);
        check(d[0] == 1'b1, "R2 rise done", d[0], 1);
        check(irq == 1'b1 && d[2], "R11 irq with notify", irq, 1);
        bus_wr(1, 32'h7);
        bus_wr(2, 32'h0000_0000);            // fall, no notify
        arm_at(4000);
        cycles(40);
        check(gpo[0] == 1'b1, "R2 fall primed high", gpo[0], 1);
        cycles(110);
        check(gpo[0] == 1'b0, "R2 fall final low", gpo[0], 0);
        bus_rd(1, d);
        check(d[0] == 1'b1, "R2 fall done", d[0], 1);
        check(irq == 1'b0 && !d[2], "R11 no irq without notify", irq, 0);
        bus_wr(1, 32'h7);
    endtask

    task automatic t_pulses;
        int h, r, s;
        logic [31:0] d;
        bus_wr(7, 32'd100);                  // 800 ns
        bus_wr(2, 32'h0000_0053);            // high pulse, sel 5
        arm_at(4000);
        watch(250, 5, h, r, s);
        check(h == 20, "R3 high pulse width", h, 20);
        check(s == 0, "R12 other outputs quiet", s, 0);
        bus_rd(1, d);
        check(d[0] == 1'b1, "R3 pulse done", d[0], 1);
        bus_wr(1, 32'h7);
        bus_wr(2, 32'h0000_0052);            // low pulse, sel 5
        arm_at(4000);
        watch(250, 5, h, r, s);
        check(250 - h == 20, "R3 low pulse width", 250 - h, 20);
        check(gpo[5] == 1'b1, "R3 low pulse idle high", gpo[5], 1);
        bus_wr(1, 32'h7);
    endtask

    task automatic t_train;
        int h, r, s;
        logic [31:0] d;
        bus_wr(5, 32'd2000);
        bus_wr(6, 32'd3);
        bus_wr(7, 32'd50);                   // 400 ns
        bus_wr(2, 32'h0000_0005);
        arm_at(4000);
        watch(400, 0, h, r, s);
        check(r == 3, "R4 train pulse count", r, 3);
        check(h == 30, "R4 train high cycles", h, 30);
        bus_rd(1, d);
        check(d[0] == 1'b1 && gpo[0] == 1'b0, "R4 train done idle", d[0], 1);
        bus_wr(1, 32'h7);
        bus_wr(5, 32'd1000);
        bus_wr(6, 32'd2);
        bus_wr(7, 32'd250);                  // 2000 ns >= cycle
        arm_at(4000);
        watch(300, 0, h, r, s);
        check(r == 2, "R6 clamp pulse count", r, 2);
        check(h == 48, "R6 clamp high cycles", h, 48);
        bus_wr(1, 32'h7);
    endtask

    task automatic t_level;
        logic [31:0] d;
        bus_wr(10, 32'd1);
        bus_wr(2, 32'h0000_0006);
        arm_at(4000);
        cycles(40);
        check(gpo[0] == 1'b0, "R7 level before target", gpo[0], 0);
        cycles(110);
        check(gpo[0] == 1'b1, "R7 level at target", gpo[0], 1);
        bus_wr(1, 32'h7);
    endtask

    task automatic t_error;
        int h, r, s;
        logic [31:0] d;
        bus_wr(2, 32'h0000_0003);            // high pulse would prime low
        arm_at(-400);
        bus_rd(1, d);
        check(d[1] == 1'b1, "R8 error flag", d[1], 1);
        bus_rd(0, d);
        check(d[0] == 1'b0, "R8 not active", d[0], 0);
        watch(150, 0, h, r, s);
        check(h == 150, "R8 output unchanged", h, 150);
        bus_rd(1, d);
        check(d[0] == 1'b0, "R8 no done", d[0], 0);
    endtask

    task automatic t_w1c;
        logic [31:0] d;
        bus_wr(2, 32'h0000_0009);            // rise with notify, level already high
        arm_at(4000);
        cycles(150);
        bus_rd(1, d);
        check(d[2:0] == 3'b111, "R10 all flags set", d[2:0], 7);
        bus_wr(1, 32'h1);
        bus_rd(1, d);
        check(d[2:0] == 3'b110, "R10 clear done only", d[2:0], 6);
        bus_wr(1, 32'h6);
        bus_rd(1, d);
        check(d[2:0] == 3'b000, "R10 clear rest", d[2:0], 0);
    endtask

    task automatic t_forever;
        int h, r, s, n;
        logic [31:0] d;
        bus_wr(5, 32'd1000);
        bus_wr(6, 32'd0);
        bus_wr(7, 32'd25);                   // 200 ns
        bus_wr(2, 32'h0000_0005);
        arm_at(4000);
        watch(400, 0, h, r, s);
        check(r >= 10, "R5 unbounded train pulses", r, 10);
        bus_rd(0, d);
        check(d[0] == 1'b1, "R5 still active", d[0], 1);
        bus_rd(1, d);
        check(d[0] == 1'b0, "R5 no done", d[0], 0);
        n = 0;
        while (gpo[0] == 1'b0 && n < 100) begin
            @(negedge clk); #1; n++;
        end
        bus_wr(0, 32'h2);
        bus_rd(0, d);
        check(d[0] == 1'b0, "R9 stop clears active", d[0], 0);
        watch(100, 0, h, r, s);
        check(h == 100, "R9 pin held after stop", h, 100);
    endtask

    initial begin
        #4000000;
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(2);
        t_reset;
        t_timebase;
        t_edges;
        t_pulses;
        t_train;
        t_level;
        t_error;
        t_w1c;
        t_forever;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule